// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block controls how a multi-output clock generator enters and leaves its low-power state. A power-down request arrives active low and asynchronous. It is resynchronized to the internal CPU-domain clock. When it acts, the block closes every output gate on a falling edge of that clock. It then waits until the reference output reports that it is held low. Only after that does it turn off the synthesizer and the crystal oscillator. The PLL, the oscillator and the pad drivers sit outside this block. It drives their enables and models PLL lock with a settle counter.

When the request is released, the block turns the oscillator and the synthesizer back on. It counts a fixed settle time and then reopens the output gates on a falling edge, so no shortened high phase reaches any output. While the block runs, the CPU and PCI output groups can be stopped by their own synchronous stop inputs. These stop inputs have no effect while power-down is being entered, is held or is being left. If the request is released partway through shutdown, the shutdown still finishes before wake-up begins.

The output enable vector has a fixed layout. The CPU group sits in the low bits, the PCI group sits above it, and the free-running outputs (reference, 48 MHz, free PCI) take the top bits.

Top module: `clk_pwrdn_seq`

## Requirements
- R1: The request `pd_req_ni` goes through a two-flop synchronizer. A low driven between rising edges k and k+1 closes the output gates in the interval after rising edge k+3, and no earlier.
- R2: On entry, every bit of `out_en_o` goes low on the same falling edge, the free-running bits included. At that point `ready_o` is already low.
- R3: `osc_en_o` and `pll_en_o` stay high until all output gates are closed. If the reference already reports low, they fall at the second rising edge after the gates close.
- R4: While the synchronized `ref_low_i` is low, shutdown waits with the oscillator and synthesizer enabled. After `ref_low_i` rises, the enables fall at the third rising edge.
- R5: While `ready_o` is high, `cpu_stop_ni`=0 clears bits [N_CPU-1:0] and `pci_stop_ni`=0 clears bits [N_CPU+N_PCI-1:N_CPU] at the next falling edge. The top N_FREE bits follow neither input. While `ready_o` is low, both stop inputs have no effect and every gate stays closed.
- R6: After the request is released, `osc_en_o` and `pll_en_o` rise at the third rising edge. `ready_o` rises at edge 3+1+SETTLE_CYC. The wake phase never lasts more than MAX_WAKE_CYC cycles.
- R7: Output gates reopen only on the falling edge after `ready_o` has risen, never in the same half cycle.
- R8: A request released during shutdown, or a request that is low for a single cycle, still drives the oscillator enable low for at least one cycle before wake-up begins.
- R9: During reset, all gates are closed, both enables are low and `ready_o` is low. After reset, if the request is high, the block wakes with the timing of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal CPU-domain clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pd_req_ni | input | 1 | Asynchronous power-down request, active low |
| ref_low_i | input | 1 | Reference output reports it is held low (asynchronous) |
| cpu_stop_ni | input | 1 | Synchronous stop for the CPU group, active low |
| pci_stop_ni | input | 1 | Synchronous stop for the PCI group, active low |
| out_en_o | output | N_CPU+N_PCI+N_FREE | Per-output gate enables, changed on falling edges |
| osc_en_o | output | 1 | Crystal oscillator enable |
| pll_en_o | output | 1 | Synthesizer enable |
| ready_o | output | 1 | Outputs released and running |

## Verification
Some properties are checked on every cycle by assertions. The oscillator is never off while a gate is open. The oscillator only falls after the reference has reported low. Every gate is closed whenever the block is not ready. The free-running gates are open whenever it is ready. The wake phase stays within its bound. Other behaviour can only be shown by the bench's scenarios: the exact edge counts through the synchronizer, the half-cycle gap between `ready_o` and the gate release, the stop inputs being ignored during power-down, and the forced completion of an interrupted or one-cycle shutdown.

// File: rtl/cps_pkg.sv
package cps_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_STOP_OUT,
    ST_WAIT_LOW,
    ST_OSC_OFF,
    ST_WAKE,
    ST_SETTLE
  } cps_state_e;
endpackage

// File: rtl/cps_sync.sv
module cps_sync #(
  parameter int          W       = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/cps_fsm.sv
module cps_fsm
  import cps_pkg::*;
#(
  parameter int SETTLE_CYC   = 16,
  parameter int MAX_WAKE_CYC = 400000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_n_s_i,
  input  logic ref_low_s_i,
  input  logic parked_i,
  output logic run_o,
  output logic osc_en_o,
  output logic pll_en_o
);
  localparam int CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam int LAT_W = $clog2(MAX_WAKE_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

  cps_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:      if (!pd_n_s_i) state_d = ST_STOP_OUT;
      ST_STOP_OUT: state_d = ST_WAIT_LOW;
      ST_WAIT_LOW: if (ref_low_s_i && parked_i) state_d = ST_OSC_OFF;
      ST_OSC_OFF:  if (pd_n_s_i) state_d = ST_WAKE;
      ST_WAKE:     state_d = ST_SETTLE;
      ST_SETTLE:   if (cnt_q == CNT_LAST) state_d = ST_RUN;
      default:     state_d = ST_OSC_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OSC_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_SETTLE) cnt_q <= cnt_q + 1'b1;
      else                      cnt_q <= '0;
    end
  end

  assign run_o    = (state_q == ST_RUN);
  assign osc_en_o = (state_q != ST_OSC_OFF);
  assign pll_en_o = (state_q != ST_OSC_OFF);

  // wake-phase length monitor
  logic [LAT_W-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          lat_q <= '0;
    else if (state_q == ST_WAKE || state_q == ST_SETTLE)  lat_q <= lat_q + 1'b1;
    else                                                  lat_q <= '0;
  end

  p_park_first_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> parked_i);
  p_ref_first_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(osc_en_o) |-> $past(ref_low_s_i));
  p_wake_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lat_q <= LAT_W'(MAX_WAKE_CYC));
  p_wake_via_settle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !run_o);
endmodule

// File: rtl/cps_gate.sv
module cps_gate #(
  parameter  int N_CPU  = 3,
  parameter  int N_PCI  = 9,
  parameter  int N_FREE = 4,
  localparam int N_OUT  = N_CPU + N_PCI + N_FREE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  output logic [N_OUT-1:0] gate_o,
  output logic             parked_o
);
  logic [N_OUT-1:0] want;
  logic [N_OUT-1:0] gate_q;

  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    if (i < N_CPU) begin : g_cpu
      assign want[i] = run_i & cpu_stop_ni;
    end else if (i < N_CPU + N_PCI) begin : g_pci
      assign want[i] = run_i & pci_stop_ni;
    end else begin : g_free
      assign want[i] = run_i;
    end
  end

  // falling-edge update: gates never cut or open a high phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= want;
  end

  assign gate_o   = gate_q;
  assign parked_o = ~|gate_q;

  p_park_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (gate_o == '0));
  p_free_runs_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (&gate_o[N_OUT-1 -: N_FREE]));
endmodule

// File: rtl/clk_pwrdn_seq.sv
module clk_pwrdn_seq #(
  parameter  int N_CPU        = 3,
  parameter  int N_PCI        = 9,
  parameter  int N_FREE       = 4,
  parameter  int SETTLE_CYC   = 16,
  parameter  int MAX_WAKE_CYC = 400000,
  localparam int N_OUT        = N_CPU + N_PCI + N_FREE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_req_ni,
  input  logic             ref_low_i,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  output logic [N_OUT-1:0] out_en_o,
  output logic             osc_en_o,
  output logic             pll_en_o,
  output logic             ready_o
);
  logic [1:0] sync_q;
  logic       run, parked;

  // reset value: request asserted, reference not yet confirmed low
  cps_sync #(.W(2), .RST_VAL(2'b00)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ref_low_i, pd_req_ni}),
    .q_o   (sync_q)
  );

  cps_fsm #(.SETTLE_CYC(SETTLE_CYC), .MAX_WAKE_CYC(MAX_WAKE_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_n_s_i   (sync_q[0]),
    .ref_low_s_i(sync_q[1]),
    .parked_i   (parked),
    .run_o      (run),
    .osc_en_o   (osc_en_o),
    .pll_en_o   (pll_en_o)
  );

  cps_gate #(.N_CPU(N_CPU), .N_PCI(N_PCI), .N_FREE(N_FREE)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .run_i      (run),
    .cpu_stop_ni(cpu_stop_ni),
    .pci_stop_ni(pci_stop_ni),
    .gate_o     (out_en_o),
    .parked_o   (parked)
  );

  assign ready_o = run;
endmodule

// File: tb/sim_clk_pwrdn_seq.sv
module sim_clk_pwrdn_seq;
  localparam int NC = 2, NP = 3, NF = 2, SC = 8, MW = 64;
  localparam int NO = NC + NP + NF;
  localparam int P_READY = 0, P_OSC = 1, P_ZERO = 2;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pd_req_ni = 1'b1, ref_low_i = 1'b1, cpu_stop_ni = 1'b1, pci_stop_ni = 1'b1;
  logic [NO-1:0] out_en;
  logic osc_en, pll_en, ready;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  clk_pwrdn_seq #(.N_CPU(NC), .N_PCI(NP), .N_FREE(NF), .SETTLE_CYC(SC), .MAX_WAKE_CYC(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pd_req_ni(pd_req_ni), .ref_low_i(ref_low_i),
    .cpu_stop_ni(cpu_stop_ni), .pci_stop_ni(pci_stop_ni),
    .out_en_o(out_en), .osc_en_o(osc_en), .pll_en_o(pll_en), .ready_o(ready));

  function automatic logic [NO-1:0] exp_mask(input logic cpu_n, input logic pci_n);
    logic [NO-1:0] m;
    for (int i = 0; i < NO; i++)
      m[i] = (i < NC) ? cpu_n : (i < NC + NP) ? pci_n : 1'b1;
    return m;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive_edge();
    @(posedge clk); #1;
  endtask

  function automatic logic probe(input int sel);
    case (sel)
      P_READY: return ready;
      P_OSC:   return osc_en;
      default: return (out_en == '0);
    endcase
  endfunction

  task automatic wait_for(input int sel, input logic val, output int n);
    n = 0;
    do begin
      @(posedge clk); #8; n++;
    end while (probe(sel) != val && n < 200);
    if (n >= 200) n = 999;
  endtask

  // from sample after WAKE entry: ready at +1+SC edges, gates half a cycle later
  task automatic tail(input logic [NO-1:0] m, input string tag);
    repeat (1 + SC) @(posedge clk);
    #1;
    chk({tag, " R6 ready"}, int'(ready), 1);
    chk({tag, " R7 gates still closed"}, int'(out_en), 0);
    #7;
    chk({tag, " R7 gates open"}, int'(out_en), int'(m));
  endtask

  task automatic do_wake(input logic [NO-1:0] m, input string tag);
    int n;
    wait_for(P_OSC, 1'b1, n);
    chk({tag, " R6 osc latency"}, n, 3);
    chk({tag, " R6 pll"}, int'(pll_en), 1);
    tail(m, tag);
  endtask

  initial begin : watchdog
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int n;
    repeat (2) @(posedge clk);
    #3;
    chk("R9 reset gates", int'(out_en), 0);
    chk("R9 reset osc", int'(osc_en), 0);
    chk("R9 reset pll", int'(pll_en), 0);
    chk("R9 reset ready", int'(ready), 0);
    drive_edge(); rst_ni = 1'b1;
    do_wake(exp_mask(1'b1, 1'b1), "R9 wake");

    // stop-input sweep while running
    for (int c = 0; c < 4; c++) begin
      drive_edge(); cpu_stop_ni = c[0]; pci_stop_ni = c[1];
      #7;
      chk("R5 stop sweep", int'(out_en), int'(exp_mask(c[0], c[1])));
      chk("R5 ready held", int'(ready), 1);
    end

    // power-down, reference already low
    drive_edge(); pd_req_ni = 1'b0;
    wait_for(P_ZERO, 1'b1, n);
    chk("R1 park latency", n, 3);
    chk("R2 ready low", int'(ready), 0);
    wait_for(P_OSC, 1'b0, n);
    chk("R3 osc off latency", n, 2);
    chk("R3 pll off", int'(pll_en), 0);

    // stop inputs ignored while down
    for (int c = 0; c < 4; c++) begin
      drive_edge(); cpu_stop_ni = c[0]; pci_stop_ni = c[1];
      #7;
      chk("R5 ignored while down", int'(out_en), 0);
    end
    drive_edge(); cpu_stop_ni = 1'b0; pci_stop_ni = 1'b1;
    drive_edge(); pd_req_ni = 1'b1;
    do_wake(exp_mask(1'b0, 1'b1), "R5 wake cpu stopped");
    drive_edge(); cpu_stop_ni = 1'b1;
    #7;
    chk("R5 cpu resumes", int'(out_en), int'(exp_mask(1'b1, 1'b1)));

    // reference not yet low, request released mid-shutdown
    drive_edge(); ref_low_i = 1'b0;
    drive_edge(); pd_req_ni = 1'b0;
    wait_for(P_ZERO, 1'b1, n);
    chk("R1 park latency 2", n, 3);
    repeat (20) @(posedge clk);
    #8;
    chk("R4 osc held on", int'(osc_en), 1);
    drive_edge(); pd_req_ni = 1'b1;
    repeat (10) @(posedge clk);
    #8;
    chk("R8 osc still on", int'(osc_en), 1);
    chk("R8 not ready", int'(ready), 0);
    drive_edge(); ref_low_i = 1'b1;
    wait_for(P_OSC, 1'b0, n);
    chk("R4 osc off after ref", n, 3);
    wait_for(P_OSC, 1'b1, n);
    chk("R8 wake after off", n, 1);
    tail(exp_mask(1'b1, 1'b1), "R8");

    // single-cycle request pulse
    drive_edge(); pd_req_ni = 1'b0;
    drive_edge(); pd_req_ni = 1'b1;
    wait_for(P_ZERO, 1'b1, n);
    chk("R1 pulse park", n, 2);
    wait_for(P_OSC, 1'b0, n);
    chk("R8 pulse osc off", n, 2);
    wait_for(P_OSC, 1'b1, n);
    chk("R8 pulse wake", n, 1);
    tail(exp_mask(1'b1, 1'b1), "R8 pulse");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule